// File: doc/BRIEF.md
# Multiplex-Aware Segment Bitmap Loader

The block holds a 32-row by 4-bit segment bitmap for a low-multiplex LCD driver. Row N drives segment output N and bit column k belongs to backplane k. A 1 means the segment is on and a 0 means it is off. The loader accepts whole data bytes and writes their bits one per clock cycle into successive rows. It starts at the most significant bit and puts 1, 2, 3 or 4 bits into each row, as the multiplex mode selects. A row pointer sets where each byte lands. The pointer can be loaded directly. Otherwise it advances by itself after every row and wraps from 31 to 0.

Two read ports are combinational. One returns the 4 bits of a single row. The other returns one backplane's bit from all 32 rows as a 32-bit word, so the waveform logic can fetch a whole column in one cycle.

Control is a two-state machine. In `ST_IDLE` the block is ready. An address load is applied, or a byte is taken on the *accept* transition into `ST_SPREAD`. The machine remains in `ST_SPREAD` (the *hold* transition) while it writes one bit per cycle. It returns to `ST_IDLE` on the *finish* transition after the eighth bit.

Top module: `seg_ram_loader`

## Requirements
- R1: A synchronous reset clears every bitmap bit to 0, sets the row pointer to 0, and leaves the block ready (`ready`=1).
- R2: `rd_row_data` equals the 4 bits of row `rd_row_addr`. Bit n of `rd_col_data` equals bit `rd_bp` of row n. Both ports are combinational.
- R3: With `mode_sel`=0 (static), the byte's bits, MSB first, go into bit 0 of 8 consecutive rows starting at the pointer. Bits 1 to 3 of those rows are unchanged.
- R4: With `mode_sel`=1 (1:2), the byte fills bits 0 and 1 of 4 consecutive rows: b7, b6 into the first row, and so on down to b1, b0 into the fourth.
- R5: With `mode_sel`=2 (1:3), the byte fills bits 0, 1 and 2 of rows p and p+1, then bits 0 and 1 of row p+2. Bit 2 of row p+2 keeps its previous value, and the next byte starts at row p+3.
- R6: With `mode_sel`=3 (1:4), b7..b4 fill bits 0..3 of row p and b3..b0 fill bits 0..3 of row p+1.
- R7: The pointer advances by one after each row is filled, and at the end of a byte. It wraps from 31 to 0. A following byte continues where the previous one stopped.
- R8: `addr_ld` while ready loads the pointer from `addr_in`. A `byte_vld` in the same cycle is dropped.
- R9: The mode is captured when a byte is accepted. Changing `mode_sel` while that byte is being written has no effect on it.
- R10: An accepted byte keeps `ready` low for exactly 8 cycles, one bit being written per cycle. `byte_vld` and `addr_ld` while `ready` is low are ignored.
- R11: Each bit is visible on the read ports in the cycle after the clock edge that writes it. The first bit (the MSB) is visible one cycle after the accepting edge, without waiting for the rest of the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| mode_sel | input | 2 | Multiplex mode: 0 static, 1 = 1:2, 2 = 1:3, 3 = 1:4 |
| addr_ld | input | 1 | Load row pointer |
| addr_in | input | 5 | Row pointer value |
| ready | output | 1 | Block idle, can accept a byte or load |
| rd_row_addr | input | 5 | Row read address |
| rd_row_data | output | 4 | Row read data |
| rd_bp | input | 2 | Backplane index for column read |
| rd_col_data | output | 32 | Column read data, bit n from row n |

## Verification
The assertions check the following on every cycle:
- The busy window lasts exactly eight cycles.
- Writes happen only while busy.
- The pointer either stays put, is loaded from `addr_in`, or steps by one with wrap at 31.
- The captured mode is frozen during a byte.

Only the bench's scenarios can show where bits actually land in each mode. That includes the untouched bit 2 in 1:3 mode, the column read contents, and the bits visible part-way through a byte.

// File: rtl/seg_ram_pkg.sv
package seg_ram_pkg;

    typedef enum logic [1:0] {
        MUX_STATIC = 2'd0,
        MUX_2      = 2'd1,
        MUX_3      = 2'd2,
        MUX_4      = 2'd3
    } mux_mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SPREAD = 1'b1
    } spread_state_e;

endpackage

// File: rtl/seg_spread_fsm.sv
module seg_spread_fsm
    import seg_ram_pkg::*;
#(
    parameter int ROWS   = 32,
    parameter int BPS    = 4,
    parameter int BYTE_W = 8,
    localparam int AW    = $clog2(ROWS),
    localparam int BW    = $clog2(BPS),
    localparam int CW    = $clog2(BYTE_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [1:0]    mode_sel,
    input  logic          addr_ld,
    input  logic [AW-1:0] addr_in,
    output logic          ready,
    output logic          wr_en,
    output logic [AW-1:0] wr_row,
    output logic [BW-1:0] wr_bit,
    output logic          wr_val,
    output logic [AW-1:0] ptr_q,
    output mux_mode_e     mode_q
);

    spread_state_e state_q, state_nx;
    logic [BYTE_W-1:0] shf_q;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bitpos_q;
    logic              last_of_byte;
    logic              last_of_row;
    logic [AW-1:0]     ptr_inc;

    assign last_of_byte = (cnt_q == CW'(BYTE_W - 1));
    assign last_of_row  = (bitpos_q == BW'(mode_q));
    assign ptr_inc      = (ptr_q == AW'(ROWS - 1)) ? '0 : ptr_q + AW'(1);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions: accept, hold, finish
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (byte_vld && !addr_ld) begin
                    state_nx = ST_SPREAD;
                end
            end
            ST_SPREAD: begin
                if (last_of_byte) begin
                    state_nx = ST_IDLE;
                end
            end
        endcase
    end

    // datapath: shift register, bit counter, row position, pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            shf_q    <= '0;
            cnt_q    <= '0;
            bitpos_q <= '0;
            ptr_q    <= '0;
            mode_q   <= MUX_STATIC;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (addr_ld) begin
                        ptr_q <= addr_in;
                    end else if (byte_vld) begin
                        shf_q    <= byte_in;
                        mode_q   <= mux_mode_e'(mode_sel);
                        cnt_q    <= '0;
                        bitpos_q <= '0;
                    end
                end
                ST_SPREAD: begin
                    shf_q <= shf_q << 1;
                    cnt_q <= cnt_q + CW'(1);
                    if (last_of_row || last_of_byte) begin
                        bitpos_q <= '0;
                        ptr_q    <= ptr_inc;
                    end else begin
                        bitpos_q <= bitpos_q + BW'(1);
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ready  = 1'b0;
        wr_en  = 1'b0;
        wr_row = ptr_q;
        wr_bit = bitpos_q;
        wr_val = shf_q[BYTE_W-1];
        unique case (state_q)
            ST_IDLE:   ready = 1'b1;
            ST_SPREAD: wr_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/seg_bitmap.sv
module seg_bitmap #(
    parameter int ROWS = 32,
    parameter int BPS  = 4,
    localparam int AW  = $clog2(ROWS),
    localparam int BW  = $clog2(BPS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_row,
    input  logic [BW-1:0]   wr_bit,
    input  logic            wr_val,
    input  logic [AW-1:0]   rd_row_addr,
    output logic [BPS-1:0]  rd_row_data,
    input  logic [BW-1:0]   rd_bp,
    output logic [ROWS-1:0] rd_col_data
);

    logic [BPS-1:0] cell_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic row_sel;
        assign row_sel = wr_en && (wr_row == AW'(r));

        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q[r] <= '0;
            end else if (row_sel) begin
                cell_q[r][wr_bit] <= wr_val;
            end
        end

        assign rd_col_data[r] = cell_q[r][rd_bp];
    end

    assign rd_row_data = cell_q[rd_row_addr];

endmodule

// File: rtl/seg_ram_loader.sv
module seg_ram_loader
    import seg_ram_pkg::*;
#(
    parameter int ROWS   = 32,
    parameter int BPS    = 4,
    parameter int BYTE_W = 8,
    localparam int AW    = $clog2(ROWS),
    localparam int BW    = $clog2(BPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [1:0]        mode_sel,
    input  logic              addr_ld,
    input  logic [AW-1:0]     addr_in,
    output logic              ready,
    input  logic [AW-1:0]     rd_row_addr,
    output logic [BPS-1:0]    rd_row_data,
    input  logic [BW-1:0]     rd_bp,
    output logic [ROWS-1:0]   rd_col_data
);

    logic          wr_en;
    logic [AW-1:0] wr_row;
    logic [BW-1:0] wr_bit;
    logic          wr_val;
    logic [AW-1:0] ptr_q;
    mux_mode_e     mode_q;

    seg_spread_fsm #(
        .ROWS   (ROWS),
        .BPS    (BPS),
        .BYTE_W (BYTE_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .mode_sel (mode_sel),
        .addr_ld  (addr_ld),
        .addr_in  (addr_in),
        .ready    (ready),
        .wr_en    (wr_en),
        .wr_row   (wr_row),
        .wr_bit   (wr_bit),
        .wr_val   (wr_val),
        .ptr_q    (ptr_q),
        .mode_q   (mode_q)
    );

    seg_bitmap #(
        .ROWS (ROWS),
        .BPS  (BPS)
    ) u_map (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_row      (wr_row),
        .wr_bit      (wr_bit),
        .wr_val      (wr_val),
        .rd_row_addr (rd_row_addr),
        .rd_row_data (rd_row_data),
        .rd_bp       (rd_bp),
        .rd_col_data (rd_col_data)
    );

endmodule

// File: rtl/seg_ram_loader_chk.sv
module seg_ram_loader_chk #(
    parameter int ROWS   = 32,
    parameter int BYTE_W = 8,
    localparam int AW    = $clog2(ROWS),
    localparam int CW    = $clog2(BYTE_W + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          ready,
    input logic          byte_vld,
    input logic          addr_ld,
    input logic [AW-1:0] addr_in,
    input logic          wr_en,
    input logic [AW-1:0] ptr,
    input logic [1:0]    mode_q
);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || ready) begin
            busy_cnt <= '0;
        end else if (busy_cnt != CW'(BYTE_W + 1)) begin
            busy_cnt <= busy_cnt + CW'(1);
        end
    end

    p_busy_max_r10: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= CW'(BYTE_W));

    p_busy_full_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> busy_cnt == CW'(BYTE_W));

    p_accept_r10: assert property (@(posedge clk) disable iff (rst)
        ready && byte_vld && !addr_ld |=> !ready);

    p_write_busy_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !ready);

    p_ptr_load_r8: assert property (@(posedge clk) disable iff (rst)
        ready && addr_ld |=> ptr == $past(addr_in));

    p_ptr_idle_r7: assert property (@(posedge clk) disable iff (rst)
        ready && !addr_ld |=> $stable(ptr));

    p_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(ready) && !$stable(ptr) |->
            ptr == (($past(ptr) == AW'(ROWS - 1)) ? '0 : $past(ptr) + AW'(1)));

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !ready && !$past(ready) |-> $stable(mode_q));

    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ready && ptr == '0);

endmodule

bind seg_ram_loader seg_ram_loader_chk #(
    .ROWS   (ROWS),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ready    (ready),
    .byte_vld (byte_vld),
    .addr_ld  (addr_ld),
    .addr_in  (addr_in),
    .wr_en    (wr_en),
    .ptr      (ptr_q),
    .mode_q   (mode_q)
);

// File: tb/seg_ram_loader_tb.sv
`timescale 1ns/1ps
module seg_ram_loader_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [1:0]  mode_sel = '0;
    logic        addr_ld = 1'b0;
    logic [4:0]  addr_in = '0;
    logic        ready;
    logic [4:0]  rd_row_addr = '0;
    logic [3:0]  rd_row_data;
    logic [1:0]  rd_bp = '0;
    logic [31:0] rd_col_data;

    int n_run = 0;
    int n_fail = 0;

    logic [3:0] mdl [32];
    int         mptr = 0;

    always #2 clk = ~clk;

    seg_ram_loader u_dut (
        .clk         (clk),
        .rst         (rst),
        .byte_vld    (byte_vld),
        .byte_in     (byte_in),
        .mode_sel    (mode_sel),
        .addr_ld     (addr_ld),
        .addr_in     (addr_in),
        .ready       (ready),
        .rd_row_addr (rd_row_addr),
        .rd_row_data (rd_row_data),
        .rd_bp       (rd_bp),
        .rd_col_data (rd_col_data)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [4:0] start;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 5'd4,  8'hA5},
        '{2'd1, 5'd12, 8'h3C},
        '{2'd2, 5'd20, 8'hD6},
        '{2'd3, 5'd0,  8'h96},
        '{2'd0, 5'd30, 8'hF0},
        '{2'd3, 5'd31, 8'h5A},
        '{2'd1, 5'd30, 8'hC3},
        '{2'd2, 5'd29, 8'hFF}
    };

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0:    return "R3";
            2'd1:    return "R4";
            2'd2:    return "R5";
            default: return "R6";
        endcase
    endfunction

    // expected placement: bpr bits per row, MSB first, row fills from bit 0
    task automatic model_byte(input logic [1:0] m, input logic [7:0] d);
        int bpr = int'(m) + 1;
        for (int i = 0; i < 8; i++) begin
            int row = (mptr + i / bpr) % 32;
            mdl[row][i % bpr] = d[7 - i];
        end
        mptr = (mptr + (8 + bpr - 1) / bpr) % 32;
    endtask

    task automatic model_clear();
        for (int r = 0; r < 32; r++) mdl[r] = '0;
        mptr = 0;
    endtask

    task automatic check_ram(input string tag);
        int bad = 0;
        for (int r = 0; r < 32; r++) begin
            rd_row_addr = 5'(r);
            #0.1;
            if (rd_row_data !== mdl[r]) begin
                bad++;
                $display("FAIL %s row %0d: got %h exp %h", tag, r, rd_row_data, mdl[r]);
            end
        end
        n_run++;
        if (bad != 0) n_fail++;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] exp_col;
            for (int r = 0; r < 32; r++) exp_col[r] = mdl[r][k];
            rd_bp = 2'(k);
            #0.1;
            n_run++;
            if (rd_col_data !== exp_col) begin
                n_fail++;
                $display("FAIL R2 %s column %0d: got %h exp %h", tag, k, rd_col_data, exp_col);
            end
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b exp %b", tag, got, exp);
        end
    endtask

    task automatic load_addr(input logic [4:0] a);
        @(negedge clk);
        addr_ld = 1'b1;
        addr_in = a;
        @(negedge clk);
        addr_ld = 1'b0;
        mptr = int'(a);
    endtask

    task automatic send_byte(input logic [1:0] m, input logic [7:0] d);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = d;
        mode_sel = m;
        @(negedge clk);
        byte_vld = 1'b0;
        while (!ready) @(negedge clk);
        model_byte(m, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_clear();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check_bit("R1 ready after reset", ready, 1'b1);
        check_ram("R1 cleared");

        // table walk: R3..R6 by mode, R7 wrap at starts 29..31
        for (int v = 0; v < 8; v++) begin
            load_addr(VECS[v].start);
            send_byte(VECS[v].mode, VECS[v].data);
            check_ram(VECS[v].start >= 5'd29 ? "R7 wrap" : mode_tag(VECS[v].mode));
        end

        // R7: auto increment, next byte continues after previous
        load_addr(5'd8);
        send_byte(2'd2, 8'h81);
        send_byte(2'd2, 8'h7E);
        send_byte(2'd3, 8'h00);
        check_ram("R7 continue");

        // R5: leftover bit 2 of the third row stays 1
        do_reset();
        for (int i = 0; i < 16; i++) send_byte(2'd3, 8'hFF);
        load_addr(5'd5);
        send_byte(2'd2, 8'h00);
        rd_row_addr = 5'd7;
        #0.1;
        check_bit("R5 leftover bit2 row7", rd_row_data[2], 1'b1);
        check_bit("R5 row7 bit0", rd_row_data[0], 1'b0);
        check_ram("R5 leftover");

        // R1: reset after activity clears RAM and pointer
        do_reset();
        check_ram("R1 re-reset");
        send_byte(2'd0, 8'hC0);
        check_ram("R1 pointer zero");

        // R11: first bit visible one cycle after accept
        do_reset();
        load_addr(5'd10);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = 8'h80;
        mode_sel = 2'd0;
        @(negedge clk);
        byte_vld = 1'b0;
        rd_row_addr = 5'd10;
        #0.1;
        check_bit("R11 msb before accept edge settles", rd_row_data[0], 1'b0);
        @(negedge clk);
        #0.1;
        check_bit("R11 msb visible", rd_row_data[0], 1'b1);
        check_bit("R11 still busy", ready, 1'b0);
        while (!ready) @(negedge clk);
        model_byte(2'd0, 8'h80);
        check_ram("R11 after byte");

        // R10: ready low exactly 8 cycles; strobes while busy ignored
        do_reset();
        load_addr(5'd16);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = 8'hB4;
        mode_sel = 2'd1;
        @(negedge clk);
        begin
            int lowc = 0;
            byte_in = 8'hFF;
            addr_ld = 1'b1;
            addr_in = 5'd2;
            while (!ready) begin
                lowc++;
                @(negedge clk);
            end
            byte_vld = 1'b0;
            addr_ld  = 1'b0;
            n_run++;
            if (lowc != 8) begin
                n_fail++;
                $display("FAIL R10 busy length: got %0d exp %0d", lowc, 8);
            end
        end
        model_byte(2'd1, 8'hB4);
        check_ram("R10 busy strobes ignored");
        send_byte(2'd0, 8'h0F);
        check_ram("R10 pointer unaffected");

        // R9: mode change mid-byte ignored
        load_addr(5'd24);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = 8'h69;
        mode_sel = 2'd3;
        @(negedge clk);
        byte_vld = 1'b0;
        mode_sel = 2'd0;
        while (!ready) @(negedge clk);
        model_byte(2'd3, 8'h69);
        check_ram("R9 mode held");

        // R8: load and byte in the same cycle, byte dropped
        @(negedge clk);
        byte_vld = 1'b1;
        addr_ld  = 1'b1;
        addr_in  = 5'd3;
        byte_in  = 8'hFF;
        mode_sel = 2'd3;
        @(negedge clk);
        byte_vld = 1'b0;
        addr_ld  = 1'b0;
        check_bit("R8 byte dropped stays ready", ready, 1'b1);
        check_ram("R8 no write");
        mptr = 3;
        send_byte(2'd0, 8'hAA);
        check_ram("R8 pointer loaded");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule